// File: doc/BRIEF.md
# Frame-Synchronous Receive Buffer

This block sits between a host that delivers image data and a downstream pixel engine. It holds one whole frame window of 8-bit pixels, three rows of 600 pixels by default, in an internal memory. Filling and draining never overlap. In the fill phase the buffer takes bytes from the host. In the drain phase it streams every stored byte to the engine, one per clock, and refuses host traffic.

While the buffer holds nothing, `ready` is high to invite the host to send a frame. The host then writes exactly `DEPTH` bytes, with idle cycles allowed between them. The accepted write that fills the buffer switches the block to the drain phase, and `proc_en` goes high. The block then reads the memory in write order on consecutive cycles, with `rd_valid` marking each byte. After the last byte the fill phase returns with both pointers at zero.

A host write strobe that arrives during the drain phase is discarded. It also sets a sticky `overrun` flag, which only reset clears.

Top module: `fbuf_frame_rx`

## Requirements
- R1: After reset, `ready`=1, `proc_en`=0, `rd_valid`=0 and `overrun`=0, and the next frame written is stored from the first location.
- R2: `ready` is high only in the fill phase while no byte of the current frame is stored. It is low in the cycle after the first accepted write and stays low through the rest of the fill, including idle cycles.
- R3: In the fill phase a byte is accepted on every clock edge where `wr_en`=1. Cycles with `wr_en`=0 store nothing, and accepted bytes keep their arrival order.
- R4: `proc_en` stays 0 until the `DEPTH`-th accepted write. It is 1, with `ready`=0, in the cycle right after that write.
- R5: In the drain phase `rd_valid` is high for exactly `DEPTH` consecutive cycles, starting one cycle after `proc_en` rises. `rd_data` presents the stored bytes in write order, and `proc_en` stays 1 until the last byte is presented.
- R6: In the cycle that presents the last byte, `proc_en`=0 and `ready`=1, and the next frame is accepted at once.
- R7: A `wr_en` pulse during the drain phase changes neither the stored data nor the byte count, and it sets `overrun` to 1 from the next cycle.
- R8: Once set, `overrun` stays 1 across later frames until reset.
- R9: `ready` and `proc_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DW (8) | Host pixel byte |
| ready | output | 1 | Buffer empty, host may start a frame |
| proc_en | output | 1 | Drain phase active |
| rd_valid | output | 1 | `rd_data` holds a valid byte |
| rd_data | output | DW (8) | Byte streamed to the downstream engine |
| overrun | output | 1 | Sticky: a write was dropped during drain |

## Verification
A write pointer that skips or repeats an address shows up on the first drain as a wrong byte at a known position. A wrong wrap point shows up as `proc_en` rising early or late against the count of writes. A read pointer that wraps at the wrong place changes the length of the `rd_valid` burst, and the burst's falling edge exposes that within one frame. A phase register that stops honouring the strobe gating corrupts the following frame's contents or leaves `overrun` clear, and either is visible within the next fill and drain pair.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;
endpackage

// File: rtl/fbuf_ptr.sv
// Wrapping address counter; advances on adv and returns to zero after DEPTH-1.
module fbuf_ptr #(
  parameter int DEPTH = 1800
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  output logic [$clog2(DEPTH)-1:0] ptr,
  output logic                     at_last,
  output logic                     at_zero
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q, ptr_d;

  assign at_last = (ptr_q == LAST);
  assign at_zero = (ptr_q == '0);
  assign ptr     = ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (at_last) ptr_d = '0;
      else         ptr_d = ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end
endmodule

// File: rtl/fbuf_mem.sv
// Storage array: one write port, one registered read port.
module fbuf_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 1800
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] rdata_q;

  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata_q <= store[raddr];
  end
endmodule

// File: rtl/fbuf_ctrl.sv
// Two-phase sequencer: fill the whole frame, then drain the whole frame.
module fbuf_ctrl
  import fbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_at_last,
  input  logic wr_at_zero,
  input  logic rd_at_last,
  output logic wr_go,
  output logic rd_go,
  output logic ready,
  output logic proc_en,
  output logic rd_valid,
  output logic overrun
);
  phase_e phase_q, phase_d;
  logic   valid_q, valid_d;
  logic   ovr_q, ovr_d;

  assign wr_go    = wr_en && (phase_q == PH_FILL);
  assign rd_go    = (phase_q == PH_DRAIN);
  assign ready    = (phase_q == PH_FILL) && wr_at_zero;
  assign proc_en  = (phase_q == PH_DRAIN);
  assign rd_valid = valid_q;
  assign overrun  = ovr_q;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_FILL:  if (wr_go && wr_at_last) phase_d = PH_DRAIN;
      PH_DRAIN: if (rd_at_last)          phase_d = PH_FILL;
      default:                           phase_d = PH_FILL;
    endcase
    valid_d = rd_go;
    ovr_d   = ovr_q || (wr_en && (phase_q == PH_DRAIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
    end
  end
endmodule

// File: rtl/fbuf_frame_rx.sv
module fbuf_frame_rx #(
  parameter int DW    = 8,
  parameter int DEPTH = 1800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          ready,
  output logic          proc_en,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          overrun
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_go, rd_go;
  logic [AW-1:0] waddr, raddr;
  logic          w_last, w_zero, r_last, r_zero;

  fbuf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_at_last (w_last),
    .wr_at_zero (w_zero),
    .rd_at_last (r_last),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .ready      (ready),
    .proc_en    (proc_en),
    .rd_valid   (rd_valid),
    .overrun    (overrun)
  );

  fbuf_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (wr_go),
    .ptr     (waddr),
    .at_last (w_last),
    .at_zero (w_zero)
  );

  fbuf_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (rd_go),
    .ptr     (raddr),
    .at_last (r_last),
    .at_zero (r_zero)
  );

  fbuf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_go),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (raddr),
    .rdata (rd_data)
  );

  logic unused_rzero;
  assign unused_rzero = r_zero;
endmodule

// File: rtl/fbuf_frame_rx_chk.sv
module fbuf_frame_rx_chk #(
  parameter int DEPTH = 1800
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic ready,
  input logic proc_en,
  input logic rd_valid,
  input logic overrun
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (rd_valid) run_q <= run_q + CW'(1);
    else               run_q <= '0;
  end

  assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, proc_en}));

  assert_drain_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proc_en) |-> $past(wr_en));

  assert_valid_after_proc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(proc_en));

  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (run_q == CW'(DEPTH)));

  assert_burst_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (run_q < CW'(DEPTH)));

  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && proc_en) |=> overrun);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_ready_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(proc_en) |-> ready);
endmodule

bind fbuf_frame_rx fbuf_frame_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .ready    (ready),
  .proc_en  (proc_en),
  .rd_valid (rd_valid),
  .overrun  (overrun)
);

// File: tb/tb_fbuf_frame_rx.sv
`timescale 1ns/1ps
module tb_fbuf_frame_rx;
  localparam int DW    = 8;
  localparam int DEPTH = 1800;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic          ready, proc_en, rd_valid, overrun;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] expq [DEPTH];
  bit ovr_exp = 1'b0;

  fbuf_frame_rx #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ready(ready), .proc_en(proc_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic t_reset_state();
    wr_en = 1'b0; wr_data = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    ovr_exp = 1'b0;
    chk(ready == 1'b1,    "R1 ready",    int'(ready),    1);
    chk(proc_en == 1'b0,  "R1 proc_en",  int'(proc_en),  0);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(overrun == 1'b0,  "R1 overrun",  int'(overrun),  0);
  endtask

  task automatic t_fill(input int seed, input bit gaps);
    chk(ready == 1'b1, "R2 ready before frame", int'(ready), 1);
    for (int k = 0; k < DEPTH; k++) begin
      if (gaps && (k % 5 == 2)) begin
        wr_en = 1'b0; wr_data = 8'h5A;
        @(posedge clk); @(negedge clk);
        chk(ready == 1'b0, "R2 ready low in idle gap", int'(ready), 0);
        chk(proc_en == 1'b0, "R3 gap not counted", int'(proc_en), 0);
      end
      expq[k] = DW'((k * seed + 3) ^ (k >> 8));
      wr_en = 1'b1; wr_data = expq[k];
      @(posedge clk); @(negedge clk);
      if (k == 0) chk(ready == 1'b0, "R2 ready after first write", int'(ready), 0);
      if (k < DEPTH - 1) begin
        if (proc_en != 1'b0) chk(1'b0, "R4 early proc_en", int'(proc_en), 0);
      end
    end
    wr_en = 1'b0;
    chk(proc_en == 1'b1, "R4 proc_en after last write", int'(proc_en), 1);
    chk(ready == 1'b0,   "R4 ready low in drain",       int'(ready),   0);
    chk(rd_valid == 1'b0, "R5 no data yet",             int'(rd_valid), 0);
  endtask

  task automatic t_drain(input bit inject);
    for (int j = 0; j < DEPTH; j++) begin
      if (inject && j >= 10 && j < 13) begin
        wr_en = 1'b1; wr_data = 8'hEE; ovr_exp = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(posedge clk); @(negedge clk);
      chk(rd_valid == 1'b1, "R5 rd_valid", int'(rd_valid), 1);
      chk(rd_data == expq[j], "R5 rd_data order", int'(rd_data), int'(expq[j]));
      chk(!(ready && proc_en), "R9 exclusive", int'({ready, proc_en}), 0);
      if (j < DEPTH - 1) begin
        chk(proc_en == 1'b1, "R5 proc_en held", int'(proc_en), 1);
      end else begin
        chk(proc_en == 1'b0, "R6 proc_en drop", int'(proc_en), 0);
        chk(ready == 1'b1,   "R6 ready back",   int'(ready),   1);
      end
      if (inject && j == 14) chk(overrun == 1'b1, "R7 overrun set", int'(overrun), 1);
    end
    wr_en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rd_valid == 1'b0, "R5 burst ends", int'(rd_valid), 0);
    chk(overrun == ovr_exp, "R8 overrun sticky", int'(overrun), int'(ovr_exp));
  endtask

  initial begin
    t_reset_state();
    t_fill(7, 1'b0);
    t_drain(1'b0);
    t_fill(13, 1'b1);
    t_drain(1'b1);
    t_fill(29, 1'b0);
    t_drain(1'b0);
    t_reset_state();
    t_fill(5, 1'b0);
    t_drain(1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule